// File: doc/BRIEF.md
# Burst SRAM Synchronous Front End

This block is the clocked control front end of a common-I/O burst SRAM. Every synchronous input is taken on the rising clock edge. From three chip enables, a host address strobe and a controller address strobe it decides what each cycle is: a deselect, a read start, a write, a burst step or an idle cycle. The decision is presented as a registered cycle kind. The address is loaded into a held register when an access begins. Per-byte write strobes, the write data and a write enable are registered toward the memory core. A burst-step pulse tells a separate address counter to advance.

The two strobes follow different rules. The host strobe is gated by the first chip enable, and its write inputs are only looked at on the following edge, where they commit a write to the held address. The controller strobe loses to an active host strobe, and it decides between read and write from the write inputs in its own cycle. The data bus is driven from the core's read data only while a read is active and the asynchronous output enable is low. It is released combinationally the moment any write input is seen.

Top module: `burst_sram_front`

## Requirements
- R1: While reset is held, cycleKind is 0 (idle), and coreWrEn, coreRdEn, burstStep, dqDrive and coreByteWr are all zero.
- R2: An access begins at a clock edge when csN0 is low, cs1 is high and csN2 is low, and an accepted strobe is low. After that edge coreAddr holds the address sampled at the edge.
- R3: hostStrobeN low has no effect while csN0 is high. With the controller strobe and advN high, the cycle is reported idle and coreAddr is unchanged.
- R4: ctrlStrobeN is ignored while hostStrobeN is low. A host start with asserted write inputs and a low controller strobe is still reported as a read (kind 2) with coreWrEn 0.
- R5: An accepted strobe whose chip enables are not all active is reported as a deselect (kind 1) and ends any active read, so dqDrive stays low.
- R6: After a host start, if the write inputs indicate a write at the next edge and no new strobe is accepted there, a write (kind 3) is issued to the held address. It uses the data on dqIn and the byte strobes sampled at that edge.
- R7: A controller-strobe start is a write (kind 3, coreWrEn 1, data and address from the same edge) when the write inputs indicate a write in that cycle. Otherwise it is a read (kind 2, coreRdEn 1).
- R8: With allWrN low, coreByteWr is all ones. Otherwise bit i is set only when byteWrEnN and byteSelN[i] are both low. No selected byte means no write, and coreWrEn equals whether any bit of coreByteWr is set.
- R9: dqDrive is high only while oeN is low, a read is active, and no write input is asserted. Asserting allWrN, or byteWrEnN together with a byte select, drops dqDrive with no clock edge. When driven, dqOut equals coreRdData.
- R10: With advN low and no accepted strobe, the cycle is a burst step (kind 4, burstStep 1). coreRdEn is 1 if a read is active, and coreAddr is unchanged.
- R11: A new accepted strobe at the edge after a host start takes priority over the pending host write: the new access is decoded on its own terms.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addrIn | input | ADDR_W | Access address |
| csN0 | input | 1 | First chip enable, active low, also gates the host strobe |
| cs1 | input | 1 | Second chip enable, active high |
| csN2 | input | 1 | Third chip enable, active low |
| hostStrobeN | input | 1 | Host address strobe, active low |
| ctrlStrobeN | input | 1 | Controller address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| allWrN | input | 1 | Global write, active low, writes every byte |
| byteWrEnN | input | 1 | Byte write enable, active low |
| byteSelN | input | NUM_BYTES | Per-byte write selects, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| dqIn | input | DATA_W | Write data from the bus |
| coreRdData | input | DATA_W | Read data from the core |
| dqOut | output | DATA_W | Data to drive onto the bus |
| dqDrive | output | 1 | Bus driver enable |
| coreAddr | output | ADDR_W | Held access address |
| coreWrData | output | DATA_W | Registered write data |
| coreByteWr | output | NUM_BYTES | Registered per-byte write strobes |
| coreWrEn | output | 1 | Write this cycle |
| coreRdEn | output | 1 | Read this cycle |
| burstStep | output | 1 | Advance the burst counter |
| cycleKind | output | 3 | 0 idle, 1 deselect, 2 read, 3 write, 4 burst |

## Verification
Two functions can meet at one edge: the deferred write commit of a host-started access, and the decode of a new strobe. The bench provokes this by presenting a fresh host strobe at a new address, with the global write asserted, on the edge right after a host start. It expects a read at the new address and no write. A second overlap sits inside one cycle: the bus drive of an active read with output enable low, and write detection. The bench raises the global write between edges and expects the driver enable to fall before any clock edge arrives.

// File: rtl/burst_sram_front_pkg.sv
package burst_sram_front_pkg;

  typedef enum logic [2:0] {
    KIND_IDLE  = 3'd0,
    KIND_DESEL = 3'd1,
    KIND_READ  = 3'd2,
    KIND_WRITE = 3'd3,
    KIND_BURST = 3'd4
  } cycle_kind_e;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic loadAddr;   // accepted access start at this edge
    logic captureWr;  // a write is taken at this edge
    logic readActive; // registered: a read is in progress
  } ctrl_strobes_t;

endpackage

// File: rtl/burst_sram_front_ctrl.sv
module burst_sram_front_ctrl
  import burst_sram_front_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          csN0,
  input  logic          cs1,
  input  logic          csN2,
  input  logic          hostStrobeN,
  input  logic          ctrlStrobeN,
  input  logic          advN,
  input  logic          wrDetect,
  output ctrl_strobes_t strobes,
  output cycle_kind_e   kindQ,
  output logic          wrEnQ,
  output logic          rdEnQ,
  output logic          burstQ
);

  logic        chipSel;
  logic        hostEvt;
  logic        ctrlEvt;
  logic        strobeEvt;
  logic        pendingQ;
  logic        readActiveQ;
  logic        readActiveNext;
  cycle_kind_e nextKind;

  assign chipSel   = !csN0 && cs1 && !csN2;
  assign hostEvt   = !hostStrobeN && !csN0;
  assign ctrlEvt   = !ctrlStrobeN && hostStrobeN;
  assign strobeEvt = hostEvt || ctrlEvt;

  always_comb begin
    nextKind = KIND_IDLE;
    if (strobeEvt) begin
      if (!chipSel)      nextKind = KIND_DESEL;
      else if (hostEvt)  nextKind = KIND_READ;
      else if (wrDetect) nextKind = KIND_WRITE;
      else               nextKind = KIND_READ;
    end else if (pendingQ && wrDetect) begin
      nextKind = KIND_WRITE;
    end else if (!advN) begin
      nextKind = KIND_BURST;
    end
  end

  always_comb begin
    readActiveNext = readActiveQ;
    unique case (nextKind)
      KIND_DESEL, KIND_WRITE: readActiveNext = 1'b0;
      KIND_READ:              readActiveNext = 1'b1;
      default:                readActiveNext = readActiveQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kindQ       <= KIND_IDLE;
      pendingQ    <= 1'b0;
      readActiveQ <= 1'b0;
      wrEnQ       <= 1'b0;
      rdEnQ       <= 1'b0;
      burstQ      <= 1'b0;
    end else begin
      kindQ       <= nextKind;
      pendingQ    <= hostEvt && chipSel;
      readActiveQ <= readActiveNext;
      wrEnQ       <= (nextKind == KIND_WRITE);
      rdEnQ       <= (nextKind == KIND_READ) ||
                     ((nextKind == KIND_BURST) && readActiveQ);
      burstQ      <= (nextKind == KIND_BURST);
    end
  end

  assign strobes.loadAddr   = strobeEvt && chipSel;
  assign strobes.captureWr  = (nextKind == KIND_WRITE);
  assign strobes.readActive = readActiveQ;

  // R4: a host start is a read whatever the controller strobe and write inputs do
  assert_host_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!hostStrobeN && !csN0 && cs1 && !csN2) |=> (kindQ == KIND_READ && !wrEnQ));

  // R3: a gated host strobe never starts or deselects
  assert_host_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!hostStrobeN && csN0) |=> (kindQ != KIND_READ && kindQ != KIND_DESEL));

  // R6: pending host write commits when nothing new is accepted
  assert_host_commit_R6: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && wrDetect && hostStrobeN && ctrlStrobeN) |=> wrEnQ);

  // R10: burst steps only follow a low advance
  assert_burst_adv_R10: assert property (@(posedge clk) disable iff (!rstN)
    burstQ |-> $past(!advN));

  // R9: a write leaves no read active for the bus driver
  assert_write_ends_read_R9: assert property (@(posedge clk) disable iff (!rstN)
    (kindQ == KIND_WRITE) |-> !readActiveQ);

endmodule

// File: rtl/burst_sram_front_dpath.sv
module burst_sram_front_dpath
  import burst_sram_front_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9,
  localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrl_strobes_t        strobes,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic                 allWrN,
  input  logic                 byteWrEnN,
  input  logic [NUM_BYTES-1:0] byteSelN,
  input  logic                 oeN,
  input  logic [DATA_W-1:0]    dqIn,
  input  logic [DATA_W-1:0]    coreRdData,
  output logic                 wrDetect,
  output logic [ADDR_W-1:0]    coreAddr,
  output logic [DATA_W-1:0]    coreWrData,
  output logic [NUM_BYTES-1:0] coreByteWr,
  output logic [DATA_W-1:0]    dqOut,
  output logic                 dqDrive
);

  logic [NUM_BYTES-1:0] maskNow;

  for (genvar lane = 0; lane < NUM_BYTES; lane++) begin : gLane
    assign maskNow[lane] = !allWrN || (!byteWrEnN && !byteSelN[lane]);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        coreWrData[lane*BYTE_W +: BYTE_W] <= '0;
        coreByteWr[lane]                  <= 1'b0;
      end else begin
        coreByteWr[lane] <= strobes.captureWr && maskNow[lane];
        if (strobes.captureWr)
          coreWrData[lane*BYTE_W +: BYTE_W] <= dqIn[lane*BYTE_W +: BYTE_W];
      end
    end
  end

  assign wrDetect = |maskNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 coreAddr <= '0;
    else if (strobes.loadAddr) coreAddr <= addrIn;
  end

  assign dqDrive = !oeN && strobes.readActive && !wrDetect;
  assign dqOut   = coreRdData;

  // R8: the global write sets every lane at the edge after capture
  assert_global_all_R8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.captureWr && !allWrN) |=> (&coreByteWr));

endmodule

// File: rtl/burst_sram_front.sv
module burst_sram_front
  import burst_sram_front_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int NUM_BYTES = 4,
  parameter int BYTE_W    = 9,
  localparam int DATA_W   = NUM_BYTES * BYTE_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    addrIn,
  input  logic                 csN0,
  input  logic                 cs1,
  input  logic                 csN2,
  input  logic                 hostStrobeN,
  input  logic                 ctrlStrobeN,
  input  logic                 advN,
  input  logic                 allWrN,
  input  logic                 byteWrEnN,
  input  logic [NUM_BYTES-1:0] byteSelN,
  input  logic                 oeN,
  input  logic [DATA_W-1:0]    dqIn,
  input  logic [DATA_W-1:0]    coreRdData,
  output logic [DATA_W-1:0]    dqOut,
  output logic                 dqDrive,
  output logic [ADDR_W-1:0]    coreAddr,
  output logic [DATA_W-1:0]    coreWrData,
  output logic [NUM_BYTES-1:0] coreByteWr,
  output logic                 coreWrEn,
  output logic                 coreRdEn,
  output logic                 burstStep,
  output logic [2:0]           cycleKind
);

  ctrl_strobes_t strobes;
  cycle_kind_e   kindQ;
  logic          wrDetect;

  burst_sram_front_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .csN0        (csN0),
    .cs1         (cs1),
    .csN2        (csN2),
    .hostStrobeN (hostStrobeN),
    .ctrlStrobeN (ctrlStrobeN),
    .advN        (advN),
    .wrDetect    (wrDetect),
    .strobes     (strobes),
    .kindQ       (kindQ),
    .wrEnQ       (coreWrEn),
    .rdEnQ       (coreRdEn),
    .burstQ      (burstStep)
  );

  burst_sram_front_dpath #(
    .ADDR_W    (ADDR_W),
    .NUM_BYTES (NUM_BYTES),
    .BYTE_W    (BYTE_W)
  ) dpath_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .addrIn     (addrIn),
    .allWrN     (allWrN),
    .byteWrEnN  (byteWrEnN),
    .byteSelN   (byteSelN),
    .oeN        (oeN),
    .dqIn       (dqIn),
    .coreRdData (coreRdData),
    .wrDetect   (wrDetect),
    .coreAddr   (coreAddr),
    .coreWrData (coreWrData),
    .coreByteWr (coreByteWr),
    .dqOut      (dqOut),
    .dqDrive    (dqDrive)
  );

  assign cycleKind = kindQ;

  // R8: write enable and byte strobes come from separate modules and must agree
  assert_enable_matches_mask_R8: assert property (@(posedge clk) disable iff (!rstN)
    coreWrEn == (coreByteWr != '0));

endmodule

// File: tb/burst_sram_front_tb_top.sv
`timescale 1ns/1ps
module burst_sram_front_tb_top;

  localparam int ADDR_W = 19;
  localparam int NB     = 4;
  localparam int BW     = 9;
  localparam int DW     = NB * BW;

  logic          clk = 1'b0;
  logic          rstN;
  logic [ADDR_W-1:0] addrIn;
  logic          csN0, cs1, csN2, hostStrobeN, ctrlStrobeN, advN;
  logic          allWrN, byteWrEnN, oeN;
  logic [NB-1:0] byteSelN;
  logic [DW-1:0] dqIn, coreRdData, dqOut, coreWrData;
  logic          dqDrive, coreWrEn, coreRdEn, burstStep;
  logic [ADDR_W-1:0] coreAddr;
  logic [NB-1:0] coreByteWr;
  logic [2:0]    cycleKind;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  burst_sram_front dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .csN0(csN0), .cs1(cs1), .csN2(csN2),
    .hostStrobeN(hostStrobeN), .ctrlStrobeN(ctrlStrobeN), .advN(advN),
    .allWrN(allWrN), .byteWrEnN(byteWrEnN), .byteSelN(byteSelN), .oeN(oeN),
    .dqIn(dqIn), .coreRdData(coreRdData), .dqOut(dqOut), .dqDrive(dqDrive),
    .coreAddr(coreAddr), .coreWrData(coreWrData), .coreByteWr(coreByteWr),
    .coreWrEn(coreWrEn), .coreRdEn(coreRdEn), .burstStep(burstStep), .cycleKind(cycleKind)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic setIdle();
    csN0 = 1'b1; cs1 = 1'b0; csN2 = 1'b1;
    hostStrobeN = 1'b1; ctrlStrobeN = 1'b1; advN = 1'b1;
    allWrN = 1'b1; byteWrEnN = 1'b1; byteSelN = '1; oeN = 1'b1;
  endtask

  task automatic selectChip();
    csN0 = 1'b0; cs1 = 1'b1; csN2 = 1'b0;
  endtask

  task automatic hostStart(input logic [ADDR_W-1:0] a);
    setIdle(); selectChip(); hostStrobeN = 1'b0; addrIn = a;
    tick();
  endtask

  task automatic tReset();
    rstN = 1'b0; setIdle(); addrIn = '0; dqIn = '0; coreRdData = '0;
    tick(); tick();
    chk("R1 kind", cycleKind, 3'd0);
    chk("R1 wrEn", coreWrEn, 0);
    chk("R1 rdEn", coreRdEn, 0);
    chk("R1 burst", burstStep, 0);
    chk("R1 drive", dqDrive, 0);
    chk("R1 byteWr", coreByteWr, 0);
    rstN = 1'b1;
    tick();
  endtask

  task automatic tHostRead();
    hostStart(19'h00123);
    chk("R2 kind read", cycleKind, 3'd2);
    chk("R2 addr", coreAddr, 19'h00123);
    chk("R2 rdEn", coreRdEn, 1);
    setIdle(); selectChip(); oeN = 1'b0; coreRdData = 36'h9ABCDEF01;
    tick();
    chk("R9 drive on read", dqDrive, 1);
    chk("R9 data out", dqOut, 36'h9ABCDEF01);
    allWrN = 1'b0;
    #1;
    chk("R9 release on write", dqDrive, 0);
    allWrN = 1'b1; byteWrEnN = 1'b0; byteSelN = 4'b1101;
    #1;
    chk("R9 release on byte write", dqDrive, 0);
    byteWrEnN = 1'b1; byteSelN = '1;
    #1;
    chk("R9 drive restored", dqDrive, 1);
    oeN = 1'b1;
    #1;
    chk("R9 oe off", dqDrive, 0);
  endtask

  task automatic tBurst();
    setIdle(); advN = 1'b0; addrIn = 19'h7FFFF;
    tick();
    chk("R10 kind burst", cycleKind, 3'd4);
    chk("R10 step", burstStep, 1);
    chk("R10 rdEn", coreRdEn, 1);
    chk("R10 addr held", coreAddr, 19'h00123);
    setIdle();
    tick();
    chk("R10 step drops", burstStep, 0);
  endtask

  task automatic tHostWrite();
    hostStart(19'h00040);
    setIdle(); byteWrEnN = 1'b0; byteSelN = 4'b1010; dqIn = 36'h123456789;
    addrIn = 19'h00999;
    tick();
    chk("R6 kind write", cycleKind, 3'd3);
    chk("R6 wrEn", coreWrEn, 1);
    chk("R8 lanes 0,2", coreByteWr, 4'b0101);
    chk("R6 addr held", coreAddr, 19'h00040);
    chk("R6 data", coreWrData, 36'h123456789);
    setIdle(); oeN = 1'b0;
    #1;
    chk("R9 no drive after write", dqDrive, 0);
    tick();
    chk("R6 single write", coreWrEn, 0);
  endtask

  task automatic tCtrlWrite();
    setIdle(); selectChip(); ctrlStrobeN = 1'b0; allWrN = 1'b0;
    byteWrEnN = 1'b0; byteSelN = 4'b1110; addrIn = 19'h000AA; dqIn = 36'hFEDCBA987;
    tick();
    chk("R7 kind write", cycleKind, 3'd3);
    chk("R8 global all", coreByteWr, 4'b1111);
    chk("R7 addr", coreAddr, 19'h000AA);
    chk("R7 data", coreWrData, 36'hFEDCBA987);
  endtask

  task automatic tCtrlRead();
    setIdle(); selectChip(); ctrlStrobeN = 1'b0; addrIn = 19'h00055;
    tick();
    chk("R7 kind read", cycleKind, 3'd2);
    chk("R7 rdEn", coreRdEn, 1);
    chk("R7 no write", coreWrEn, 0);
  endtask

  task automatic tNoByteWrite();
    setIdle(); selectChip(); ctrlStrobeN = 1'b0; byteWrEnN = 1'b1; byteSelN = '0;
    addrIn = 19'h00066;
    tick();
    chk("R8 no select is read", cycleKind, 3'd2);
    chk("R8 no strobes", coreByteWr, 0);
    setIdle(); selectChip(); ctrlStrobeN = 1'b0; byteWrEnN = 1'b0; byteSelN = '1;
    tick();
    chk("R8 enable without select", coreWrEn, 0);
  endtask

  task automatic tCtrlIgnored();
    setIdle(); selectChip(); hostStrobeN = 1'b0; ctrlStrobeN = 1'b0; allWrN = 1'b0;
    addrIn = 19'h00077;
    tick();
    chk("R4 kind read", cycleKind, 3'd2);
    chk("R4 no write", coreWrEn, 0);
    chk("R4 addr", coreAddr, 19'h00077);
    setIdle();
    tick();
  endtask

  task automatic tHostGated();
    setIdle(); cs1 = 1'b1; csN2 = 1'b0; csN0 = 1'b1; hostStrobeN = 1'b0;
    addrIn = 19'h01234;
    tick();
    chk("R3 kind idle", cycleKind, 3'd0);
    chk("R3 addr unchanged", coreAddr, 19'h00077);
  endtask

  task automatic tDeselect();
    hostStart(19'h00011);
    setIdle(); csN0 = 1'b0; cs1 = 1'b0; csN2 = 1'b0; hostStrobeN = 1'b0;
    addrIn = 19'h00022;
    tick();
    chk("R5 kind deselect", cycleKind, 3'd1);
    chk("R5 addr kept", coreAddr, 19'h00011);
    setIdle(); oeN = 1'b0;
    #1;
    chk("R5 read ended", dqDrive, 0);
    setIdle(); csN0 = 1'b0; cs1 = 1'b1; csN2 = 1'b1; ctrlStrobeN = 1'b0;
    tick();
    chk("R5 third enable", cycleKind, 3'd1);
  endtask

  task automatic tCollision();
    hostStart(19'h00100);
    setIdle(); selectChip(); hostStrobeN = 1'b0; allWrN = 1'b0; addrIn = 19'h00200;
    tick();
    chk("R11 new strobe read", cycleKind, 3'd2);
    chk("R11 no commit", coreWrEn, 0);
    chk("R11 new addr", coreAddr, 19'h00200);
    setIdle();
    tick();
  endtask

  initial begin
    tReset();
    tHostRead();
    tBurst();
    tHostWrite();
    tCtrlWrite();
    tCtrlRead();
    tNoByteWrite();
    tCtrlIgnored();
    tHostGated();
    tDeselect();
    tCollision();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule